// File: doc/BRIEF.md
# Register List Save/Restore Sequencer

This block handles the stack traffic around a function call. The caller supplies a 12-bit mask that selects registers 20 to 31, a 5-bit frame size counted in words, and a mode. In save mode the block pushes each selected register onto the stack, one word at a time. It then lowers the stack pointer by the frame size. In restore mode it first raises the stack pointer by the frame size and then pops the selected registers back.

When a restore finishes, the block can also hand back a jump target read from a register that the caller names. The block drives a single-ported register file and a word-wide memory port. The memory port has a request/acknowledge handshake. Bits that are clear in the mask are skipped without spending a cycle. Each selected register costs exactly one memory transaction.

Top module: `frame_seq`

## Requirements
- R1: After reset, `done`, `jumpValid`, `memReq` and `rfWrEn` are low and `spOut` is zero.
- R2: Mask bit i (0 to 11) selects register number 20+i. Registers whose bit is clear are neither stored nor written.
- R3: Save visits the selected registers from the lowest number to the highest. For each one the stack pointer first drops by 4, and then the register is stored at the new pointer. Lower-numbered registers therefore land at higher addresses.
- R4: Once all saves are done, the stack pointer drops by a further `frameImm`×4 bytes.
- R5: Restore first raises the stack pointer by `frameImm`×4. It then visits the selected registers from the highest number to the lowest, loading each one from the stack pointer and then adding 4.
- R6: During a restore, the register-file write happens in the same cycle as the memory acknowledge, and at no other time.
- R7: A run makes one memory transaction per selected register. An empty mask makes none and only applies the frame adjustment.
- R8: A restore with a nonzero `jumpIdx` reads that register after all pops are done. It presents the value on `jumpTarget`, with `jumpValid` high during the `done` cycle. Index 0, and save mode, never raise `jumpValid`.
- R9: `done` is a single-cycle pulse at the end of a run. `spOut` then holds the final stack pointer.
- R10: While a request waits for its acknowledge, `memReq` stays high and `memAddr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| modeRestore | input | 1 | 0 = save, 1 = restore |
| listMask | input | 12 | Bit i selects register 20+i |
| frameImm | input | 5 | Frame size in words |
| jumpIdx | input | 5 | Register holding the jump target, 0 = none |
| spIn | input | 32 | Stack pointer at start |
| rfAddr | output | 5 | Register-file index |
| rfRdData | input | 32 | Register-file read data (same cycle) |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrData | output | 32 | Register-file write data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = store, 0 = load |
| memAddr | output | 32 | Byte address, word aligned |
| memWrData | output | 32 | Store data |
| memAck | input | 1 | Memory acknowledge |
| memRdData | input | 32 | Load data, valid with acknowledge |
| spOut | output | 32 | Current stack pointer |
| jumpTarget | output | 32 | Jump target after a restore |
| jumpValid | output | 1 | Jump target is valid (with done) |
| done | output | 1 | End-of-run pulse |

## Verification
The properties assume four things about the environment:
- `memAck` only rises while `memReq` is high, and it lasts one cycle.
- The register file answers reads in the same cycle.
- `memRdData` is valid with the acknowledge.
- `start` is only raised while the block is idle.

The bench's memory model acknowledges only outstanding requests, and it adds a random wait of zero to two cycles. Its register-file model reads combinationally. A new run is started only after `done` has been seen.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FRAME_UP,
    S_XFER,
    S_FRAME_DN,
    S_JUMP,
    S_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic frameUp;
    logic frameDn;
    logic stepDn;
    logic stepUp;
    logic latchJump;
  } dpCmd_t;

endpackage

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LIST_N    = 12,
  parameter int LIST_BASE = 20,
  parameter int IMM_W     = 5,
  parameter int RIDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [LIST_N-1:0] listMask,
  input  logic [IMM_W-1:0]  frameImm,
  input  logic [RIDX_W-1:0] jumpIdx,
  input  logic              modeRestore,
  input  logic [DATA_W-1:0] rfRdData,
  output logic [ADDR_W-1:0] spOut,
  output logic              pendingEmpty,
  output logic              restoreQ,
  output logic              jumpWanted,
  output logic [RIDX_W-1:0] xferReg,
  output logic [RIDX_W-1:0] jumpReg,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] jumpTarget
);

  localparam int IDX_W      = $clog2(LIST_N);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_SH    = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] sp;
  logic [LIST_N-1:0] pending;
  logic [IMM_W-1:0]  immQ;
  logic [RIDX_W-1:0] jmpQ;
  logic              modeQ;
  logic [IDX_W-1:0]  pickIdx;
  logic [ADDR_W-1:0] frameBytes;

  // zero-cycle skip: priority search over what is left of the mask
  always_comb begin
    pickIdx = '0;
    if (modeQ) begin
      for (int i = 0; i < LIST_N; i++)
        if (pending[i]) pickIdx = IDX_W'(i);
    end else begin
      for (int i = LIST_N - 1; i >= 0; i--)
        if (pending[i]) pickIdx = IDX_W'(i);
    end
  end

  assign frameBytes   = ADDR_W'(immQ) << WORD_SH;
  assign pendingEmpty = (pending == '0);
  assign restoreQ     = modeQ;
  assign jumpWanted   = (jmpQ != '0);
  assign jumpReg      = jmpQ;
  assign xferReg      = RIDX_W'(LIST_BASE) + RIDX_W'(pickIdx);
  assign memAddr      = modeQ ? sp : sp - ADDR_W'(WORD_BYTES);
  assign spOut        = sp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp         <= '0;
      pending    <= '0;
      immQ       <= '0;
      jmpQ       <= '0;
      modeQ      <= 1'b0;
      jumpTarget <= '0;
    end else begin
      if (cmd.capture) begin
        sp      <= spIn;
        pending <= listMask;
        immQ    <= frameImm;
        jmpQ    <= jumpIdx;
        modeQ   <= modeRestore;
      end else if (cmd.frameUp) begin
        sp <= sp + frameBytes;
      end else if (cmd.frameDn) begin
        sp <= sp - frameBytes;
      end else if (cmd.stepDn) begin
        sp               <= sp - ADDR_W'(WORD_BYTES);
        pending[pickIdx] <= 1'b0;
      end else if (cmd.stepUp) begin
        sp               <= sp + ADDR_W'(WORD_BYTES);
        pending[pickIdx] <= 1'b0;
      end
      if (cmd.latchJump) jumpTarget <= rfRdData;
    end
  end

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   modeRestore,
  input  logic   pendingEmpty,
  input  logic   restoreQ,
  input  logic   jumpWanted,
  input  logic   memAck,
  output dpCmd_t cmd,
  output logic   memReq,
  output logic   memWe,
  output logic   rfWrEn,
  output logic   done,
  output logic   jumpValid
);

  seqState_t state, stateNext;
  logic      jumpFlag;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    rfWrEn    = 1'b0;
    done      = 1'b0;
    jumpValid = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          cmd.capture = 1'b1;
          stateNext   = modeRestore ? S_FRAME_UP : S_XFER;
        end
      end
      S_FRAME_UP: begin
        cmd.frameUp = 1'b1;
        stateNext   = S_XFER;
      end
      S_XFER: begin
        if (pendingEmpty) begin
          if (!restoreQ)       stateNext = S_FRAME_DN;
          else if (jumpWanted) stateNext = S_JUMP;
          else                 stateNext = S_DONE;
        end else begin
          memReq = 1'b1;
          memWe  = !restoreQ;
          if (memAck) begin
            cmd.stepDn = !restoreQ;
            cmd.stepUp = restoreQ;
            rfWrEn     = restoreQ;
          end
        end
      end
      S_FRAME_DN: begin
        cmd.frameDn = 1'b1;
        stateNext   = S_DONE;
      end
      S_JUMP: begin
        cmd.latchJump = 1'b1;
        stateNext     = S_DONE;
      end
      S_DONE: begin
        done      = 1'b1;
        jumpValid = jumpFlag;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      jumpFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (cmd.capture)        jumpFlag <= 1'b0;
      else if (cmd.latchJump) jumpFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LIST_N    = 12,
  parameter int LIST_BASE = 20,
  parameter int IMM_W     = 5,
  parameter int RIDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeRestore,
  input  logic [LIST_N-1:0] listMask,
  input  logic [IMM_W-1:0]  frameImm,
  input  logic [RIDX_W-1:0] jumpIdx,
  input  logic [ADDR_W-1:0] spIn,
  output logic [RIDX_W-1:0] rfAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] spOut,
  output logic [DATA_W-1:0] jumpTarget,
  output logic              jumpValid,
  output logic              done
);

  dpCmd_t            cmd;
  logic              pendingEmpty;
  logic              restoreQ;
  logic              jumpWanted;
  logic [RIDX_W-1:0] xferReg;
  logic [RIDX_W-1:0] jumpReg;

  frame_seq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .modeRestore  (modeRestore),
    .pendingEmpty (pendingEmpty),
    .restoreQ     (restoreQ),
    .jumpWanted   (jumpWanted),
    .memAck       (memAck),
    .cmd          (cmd),
    .memReq       (memReq),
    .memWe        (memWe),
    .rfWrEn       (rfWrEn),
    .done         (done),
    .jumpValid    (jumpValid)
  );

  frame_seq_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LIST_N    (LIST_N),
    .LIST_BASE (LIST_BASE),
    .IMM_W     (IMM_W),
    .RIDX_W    (RIDX_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .spIn         (spIn),
    .listMask     (listMask),
    .frameImm     (frameImm),
    .jumpIdx      (jumpIdx),
    .modeRestore  (modeRestore),
    .rfRdData     (rfRdData),
    .spOut        (spOut),
    .pendingEmpty (pendingEmpty),
    .restoreQ     (restoreQ),
    .jumpWanted   (jumpWanted),
    .xferReg      (xferReg),
    .jumpReg      (jumpReg),
    .memAddr      (memAddr),
    .jumpTarget   (jumpTarget)
  );

  assign rfAddr    = cmd.latchJump ? jumpReg : xferReg;
  assign rfWrData  = memRdData;
  assign memWrData = rfRdData;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] spOut,
  input logic              rfWrEn,
  input logic              done,
  input logic              jumpValid
);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && memWe |=> spOut == $past(memAddr));

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !memWe |=> spOut == $past(memAddr) + ADDR_W'(4));

  p_wr_on_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> memReq && memAck && !memWe);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_jump_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    jumpValid |-> done);

  p_quiet_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

endmodule

bind frame_seq frame_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .spOut     (spOut),
  .rfWrEn    (rfWrEn),
  .done      (done),
  .jumpValid (jumpValid)
);

// File: tb/frame_seq_tb_top.sv
`timescale 1ns/1ps
module frame_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        modeRestore = 1'b0;
  logic [11:0] listMask = '0;
  logic [4:0]  frameImm = '0;
  logic [4:0]  jumpIdx = '0;
  logic [31:0] spIn = '0;
  logic [4:0]  rfAddr;
  logic [31:0] rfRdData;
  logic        rfWrEn;
  logic [31:0] rfWrData;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWrData, memRdData = '0;
  logic [31:0] spOut, jumpTarget;
  logic        jumpValid, done;

  always #10 clk = ~clk;  // 50 MHz

  frame_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeRestore(modeRestore),
    .listMask(listMask), .frameImm(frameImm), .jumpIdx(jumpIdx), .spIn(spIn),
    .rfAddr(rfAddr), .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrData(rfWrData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memAck(memAck), .memRdData(memRdData), .spOut(spOut),
    .jumpTarget(jumpTarget), .jumpValid(jumpValid), .done(done)
  );

  int errors = 0;
  int checks = 0;

  logic [31:0] rf [32];
  logic [31:0] mem [128];
  logic [31:0] addrLog [64];
  int          xferCount = 0;
  int          wrNoAck = 0;
  int          stabFail = 0;
  int          waitCnt = 0;
  logic        prevWaiting = 1'b0;
  logic [31:0] prevAddr = '0;
  int          cyc = 0;

  assign rfRdData = rf[rfAddr];

  always @(posedge clk) begin
    if (rfWrEn) rf[rfAddr] <= rfWrData;
    if (rfWrEn && !memAck) wrNoAck <= wrNoAck + 1;
  end

  // memory model with 0..2 wait cycles
  always @(posedge clk) begin
    if (prevWaiting && memReq && memAddr != prevAddr) stabFail <= stabFail + 1;
    prevWaiting <= memReq && !memAck;
    prevAddr    <= memAddr;
    if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (waitCnt == 0) begin
        memAck <= 1'b1;
        if (memWe) mem[memAddr[8:2]] <= memWrData;
        memRdData <= mem[memAddr[8:2]];
        addrLog[xferCount % 64] <= memAddr;
        xferCount <= xferCount + 1;
        waitCnt <= int'($urandom % 3);
      end else begin
        waitCnt <= waitCnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finishRun();
    end
  end

  logic [31:0] resSp, resTarget, resFirst;
  logic        resJv;
  int          resXfers;

  task automatic runOp(input bit rest, input logic [11:0] m, input logic [4:0] imm,
                       input logic [4:0] j, input logic [31:0] sp0);
    int base;
    int lim;
    @(negedge clk);
    base = xferCount;
    modeRestore = rest; listMask = m; frameImm = imm; jumpIdx = j; spIn = sp0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = 0;
    while (!done && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
    if (lim >= 2000) check(1'b0, "R9 done timeout", 32'(lim), 32'd0);
    resSp = spOut; resJv = jumpValid; resTarget = jumpTarget;
    resXfers = xferCount - base;
    resFirst = addrLog[base % 64];
    @(negedge clk);
    check(!done, "R9 done single pulse", {31'd0, done}, 32'd0);
  endtask

  typedef struct packed {
    logic [11:0] mask;
    logic [4:0]  imm;
    logic [4:0]  jmp;
    logic [31:0] delta;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{12'h000, 5'd0,  5'd0,  32'd0},
    '{12'hFFF, 5'd31, 5'd0,  32'd172},
    '{12'h001, 5'd1,  5'd0,  32'd8},
    '{12'h800, 5'd0,  5'd31, 32'd4},
    '{12'hA5A, 5'd7,  5'd25, 32'd52},
    '{12'h3C0, 5'd16, 5'd3,  32'd80}
  };

  localparam logic [31:0] SP_INIT = 32'h0000_01F0;

  task automatic runCase(input int n, input logic [11:0] m, input logic [4:0] imm,
                         input logic [4:0] j, input logic [31:0] delta);
    logic [31:0] saved [12];
    logic [31:0] spAfter;
    int bad;
    int k;
    for (int i = 0; i < 12; i++) begin
      saved[i] = 32'h5A00_0000 ^ (32'(n) << 8) ^ 32'(i);
      rf[20 + i] = saved[i];
    end
    for (int a = 0; a < 128; a++) mem[a] = 32'hFFFF_0000 | 32'(a);
    if (j != 0 && j < 20) rf[j] = 32'h7700_0000 | 32'(n);

    runOp(1'b0, m, imm, j, SP_INIT);
    spAfter = resSp;
    check(resSp == SP_INIT - delta, "R4 save final sp", resSp, SP_INIT - delta);
    check(resXfers == $countones(m), "R7 save transaction count",
          32'(resXfers), 32'($countones(m)));
    check(!resJv, "R8 no jump in save mode", {31'd0, resJv}, 32'd0);
    if (m != 0) check(resFirst == SP_INIT - 4, "R3 first store address", resFirst, SP_INIT - 4);
    bad = 0; k = 0;
    for (int i = 0; i < 12; i++) if (m[i]) begin
      k++;
      if (mem[(SP_INIT - 32'(4 * k)) >> 2] != saved[i]) bad++;
    end
    check(bad == 0, "R3 R2 memory image after save", 32'(bad), 32'd0);

    for (int i = 0; i < 12; i++) rf[20 + i] = 32'hBAD0_0000 | 32'(i);

    runOp(1'b1, m, imm, j, spAfter);
    check(resSp == SP_INIT, "R5 restore final sp", resSp, SP_INIT);
    check(resXfers == $countones(m), "R7 restore transaction count",
          32'(resXfers), 32'($countones(m)));
    if (m != 0) check(resFirst == spAfter + 32'(imm) * 4, "R5 frame applied before pops",
                      resFirst, spAfter + 32'(imm) * 4);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (m[i]  && rf[20 + i] != saved[i]) bad++;
      if (!m[i] && rf[20 + i] != (32'hBAD0_0000 | 32'(i))) bad++;
    end
    check(bad == 0, "R2 R5 register contents after restore", 32'(bad), 32'd0);
    if (j != 0) begin
      check(resJv, "R8 jump valid", {31'd0, resJv}, 32'd1);
      check(resTarget == rf[j], "R8 jump target after pops", resTarget, rf[j]);
    end else begin
      check(!resJv, "R8 index zero means no jump", {31'd0, resJv}, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 | 32'(i);
    for (int a = 0; a < 128; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !jumpValid && !memReq && !rfWrEn, "R1 outputs idle in reset",
          {28'd0, done, jumpValid, memReq, rfWrEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(spOut == 32'd0, "R1 sp zero after reset", spOut, 32'd0);

    for (int v = 0; v < 6; v++)
      runCase(v, VECS[v].mask, VECS[v].imm, VECS[v].jmp, VECS[v].delta);

    for (int r = 0; r < 20; r++) begin
      logic [11:0] m;
      logic [4:0]  imm;
      logic [4:0]  j;
      m   = 12'($urandom);
      imm = 5'($urandom);
      j   = 5'($urandom);
      runCase(100 + r, m, imm, j, 32'($countones(m)) * 4 + 32'(imm) * 4);
    end

    check(wrNoAck == 0, "R6 register write only with acknowledge", 32'(wrNoAck), 32'd0);
    check(stabFail == 0, "R10 address stable while waiting", 32'(stabFail), 32'd0);
    finishRun();
  end

endmodule